// File: doc/BRIEF.md
# Trigger Hit Stretcher and Serializer

This block sits between the per-channel hit detectors of a drift-chamber front end and a serial trigger link. Each channel raises a hit bit at the fast sample rate when a timing edge falls in the sample period or when the pulse amplitude crosses its threshold. Such a hit can last a single fast cycle, which a slower trigger sampler would miss. The block therefore holds every hit in a per-channel sticky latch until the next trigger-rate sampling instant.

At each trigger-rate instant the latches are copied into a shadow word and then cleared. A serializer sends the shadow word over one serial line, one bit per link-clock enable, with channel 0 first. A frame marker flags the first bit of every 16-bit frame. The link runs at about sixteen times the trigger rate, so the frames follow one another with no gap.

All logic uses one clock. Three enables mark the fast sample instants, the trigger sampling instants and the link bit instants. Line coding and the optical transmitter are handled further down the link.

Top module: `trig_hit_serializer`

## Requirements
- R1: While reset is held and after it is released, ser_o and frame_o are 0. Every frame sent before the first trig_en_i cycle carries all zero bits.
- R2: A hit_i bit that is high for even one clock cycle with fast_en_i high is held in its channel latch. It appears as a 1 in the first frame loaded after the next trig_en_i cycle.
- R3: hit_i has no effect in a cycle where fast_en_i is low.
- R4: In a trig_en_i cycle, the latches are copied to the shadow word and cleared. A hit taken in that same cycle (fast_en_i high) counts toward the following period, not the one being sampled.
- R5: A frame is 16 bits, sent with channel 0 first (bit index i of the frame = channel i). One bit goes out per link_en_i cycle and appears on ser_o after that clock edge. ser_o and frame_o hold their values in cycles where link_en_i is low.
- R6: frame_o is 1 exactly while bit 0 of a frame is on ser_o, so consecutive markers are 16 link bits apart.
- R7: The serializer takes the shadow word when a frame starts. A trig_en_i capture during a frame does not alter the frame in flight. If no new capture has happened, a frame repeats the last shadow word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Single system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_i | input | 16 | Per-channel fast hit bits |
| fast_en_i | input | 1 | Fast sample instant enable |
| trig_en_i | input | 1 | Trigger sampling instant enable |
| link_en_i | input | 1 | Link bit instant enable |
| ser_o | output | 1 | Serial trigger bit |
| frame_o | output | 1 | High with the first bit of each frame |

## Verification
A reference model on the bench tracks the latches, the shadow word and the frame position. It queues the word each frame should carry, and a monitor rebuilds frames from ser_o and compares them. The stimulus includes:
- a walking one across the channels, which exposes bit-order and channel-swap faults;
- single-cycle pulses placed between sampling instants, which show whether stretching works;
- hits that coincide with a sampling instant, which separate a clear-then-set latch from one that drops or double-counts the hit;
- hits while fast_en_i is low, which must not appear in any frame;
- random patterns with gaps in link_en_i and trigger instants at varying phases, which test output holding and the shadow isolation of frames in flight.

// File: rtl/trig_ser_pkg.sv
package trig_ser_pkg;
  parameter int unsigned N_CH = 16;
  localparam int unsigned CNT_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  typedef logic [N_CH-1:0] ch_vec_t;
endpackage

// File: rtl/hit_stretch_cell.sv
module hit_stretch_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic fast_en_i,
  input  logic trig_en_i,
  output logic latch_o
);
  logic latch_q;
  logic hit_take;

  assign hit_take = fast_en_i & hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         latch_q <= 1'b0;
    else if (trig_en_i)  latch_q <= hit_take;  // new period starts
    else if (hit_take)   latch_q <= 1'b1;
  end

  assign latch_o = latch_q;

  AST_CLEAR_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_en_i && !fast_en_i) |=> !latch_o);  // R4
  AST_STICKY_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_en_i && hit_i) |=> latch_o);  // R2
  AST_IDLE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_en_i && !fast_en_i) |=> $stable(latch_o));  // R3
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import trig_ser_pkg::*;
#(
  parameter int unsigned WIDTH = N_CH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] word_i,
  input  logic             link_en_i,
  output logic             ser_o,
  output logic             frame_o
);
  localparam int unsigned PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(WIDTH - 1);

  logic [PW-1:0]    pos_q;
  logic [WIDTH-1:0] sh_q;
  logic             ser_q, frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      sh_q    <= '0;
      ser_q   <= 1'b0;
      frame_q <= 1'b0;
    end else if (link_en_i) begin
      if (pos_q == '0) begin
        ser_q   <= word_i[0];
        sh_q    <= word_i >> 1;
        frame_q <= 1'b1;
      end else begin
        ser_q   <= sh_q[0];
        sh_q    <= sh_q >> 1;
        frame_q <= 1'b0;
      end
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  assign ser_o   = ser_q;
  assign frame_o = frame_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_en_i |=> ($stable(ser_o) && $stable(frame_o)));  // R5
  AST_MARK_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_i && pos_q == '0) |=> (frame_o && ser_o == $past(word_i[0])));  // R6
  AST_NO_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_i && pos_q != '0) |=> !frame_o);  // R6
endmodule

// File: rtl/trig_hit_serializer.sv
module trig_hit_serializer
  import trig_ser_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] hit_i,
  input  logic            fast_en_i,
  input  logic            trig_en_i,
  input  logic            link_en_i,
  output logic            ser_o,
  output logic            frame_o
);
  ch_vec_t latch_w;
  ch_vec_t shadow_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    hit_stretch_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit_i[g]),
      .fast_en_i(fast_en_i),
      .trig_en_i(trig_en_i),
      .latch_o  (latch_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        shadow_q <= '0;
    else if (trig_en_i) shadow_q <= latch_w;
  end

  frame_serializer #(.WIDTH(N_CH)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .word_i   (shadow_q),
    .link_en_i(link_en_i),
    .ser_o    (ser_o),
    .frame_o  (frame_o)
  );

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_en_i |=> $stable(shadow_q));  // R7
  AST_SHADOW_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_en_i |=> (shadow_q == $past(latch_w)));  // R4
endmodule

// File: tb/tb_trig_hit_serializer.sv
module tb_trig_hit_serializer;
  localparam int NC = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NC-1:0] hit_i = '0;
  logic fast_en_i = 1'b0, trig_en_i = 1'b0, link_en_i = 1'b0;
  logic ser_o, frame_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  trig_hit_serializer dut (.*);

  always #5 clk_i = ~clk_i;

  // reference model of the requirements
  logic [NC-1:0] m_latch = '0, m_shadow = '0;
  int m_pos = 0;
  logic [NC-1:0] expq[$];
  logic le_q = 1'b0;

  always @(posedge clk_i) begin
    le_q <= rst_ni & link_en_i;
    if (rst_ni) begin
      if (link_en_i) begin
        if (m_pos == 0) expq.push_back(m_shadow);  // R7 word taken at frame start
        m_pos = (m_pos + 1) % NC;
      end
      if (trig_en_i) begin
        m_shadow = m_latch;
        m_latch  = fast_en_i ? hit_i : '0;          // R4
      end else if (fast_en_i) begin
        m_latch = m_latch | hit_i;                  // R2, R3
      end
    end
  end

  // monitor: rebuild frames and compare
  logic [NC-1:0] got = '0;
  int nbits = 0;
  bit started = 0;

  task automatic close_frame();
    logic [NC-1:0] exp_w;
    n_chk++;
    if (expq.size() == 0) begin
      n_bad++;
      $display("FAIL R5 frame %h arrived with no expected word (exp none)", got);
    end else begin
      exp_w = expq.pop_front();
      if (got !== exp_w) begin
        n_bad++;
        $display("FAIL R2/R4/R5/R7 frame got %h exp %h", got, exp_w);
      end
    end
  endtask

  always @(negedge clk_i) begin
    if (le_q && !done) begin
      if (frame_o) begin
        if (started) begin
          n_chk++;
          if (nbits != NC) begin
            n_bad++;
            $display("FAIL R6 marker spacing got %0d exp %0d", nbits, NC);
          end else close_frame();
        end
        started = 1;
        got = '0;
        got[0] = ser_o;
        nbits = 1;
      end else if (started) begin
        if (nbits < NC) got[nbits] = ser_o;
        nbits++;
      end
    end
  end

  task automatic step(input logic [NC-1:0] h, input logic fe, input logic te, input logic le);
    @(negedge clk_i);
    hit_i = h; fast_en_i = fe; trig_en_i = te; link_en_i = le;
  endtask

  task automatic chk_idle(input string tag);
    n_chk++;
    if (ser_o !== 1'b0 || frame_o !== 1'b0) begin
      n_bad++;
      $display("FAIL %s outputs got ser=%b mark=%b exp 0 0", tag, ser_o, frame_o);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R1 in reset");
    step('0, 0, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1 after reset");
    // R1: zero frames before the first trigger sample, hits present
    for (int c = 0; c < 40; c++) step(16'hFFFF, 1, 0, 1);
    // R5: walking one, trig every 16 cycles, link every cycle
    for (int c = 0; c < 16 * 20; c++)
      step(16'(1 << ((c / 16) % NC)) & {16{(c % 16) == 3}}, 1, (c % 16) == 9, 1);
    // R2: single-cycle pulses between samples
    for (int c = 0; c < 16 * 8; c++)
      step((c % 16 == 5) ? 16'(16'hA5C3 >> (c / 16)) : '0, 1, (c % 16) == 0, 1);
    // R4: hits exactly on the sampling cycle
    for (int c = 0; c < 16 * 8; c++)
      step((c % 16 == 0) ? 16'(16'h1 << (c / 16)) : '0, 1, (c % 16) == 0, 1);
    // R3: hits with fast_en low
    for (int c = 0; c < 16 * 6; c++)
      step(16'hFFFF, 0, (c % 16) == 7, 1);
    // R7: no new samples, frames repeat the shadow
    for (int c = 0; c < 16; c++) step(16'h8001, 1, c == 2, 1);
    for (int c = 0; c < 16 * 4; c++) step('0, 0, 0, 1);
    // R5, R7: random patterns, link gaps, trig at random phase
    for (int c = 0; c < 3000; c++)
      step(16'($urandom) & 16'($urandom), 1'($urandom % 3 == 0),
           1'($urandom % 23 == 0), 1'($urandom % 4 != 0));
    // drain: complete the frame in flight
    for (int c = 0; c < 40; c++) step('0, 0, 0, 1);
    step('0, 0, 0, 0);
    repeat (2) @(negedge clk_i);
    n_chk++;
    if (n_chk < 12) begin
      n_bad++;
      $display("FAIL R5 frame count got %0d exp >= 12", n_chk);
    end
    finish_run();
  end
endmodule